// File: doc/BRIEF.md
# SD SPI Data Block Engine

This block handles the data phase of an SD card session run over SPI. A command sequencer issues the read or write command elsewhere. Once the card has accepted that command, this engine moves whole data blocks between a host byte stream and the card. Every card byte is one full-duplex exchange on a byte-wide exchange port. A separate SPI shifter serves that port: it shifts `xfer_tx` out while it captures `xfer_rx`, and it pulses `xfer_done` when the exchange is finished.

On a read, the engine clocks filler bytes and watches for the start token. It then passes each data byte to the host on a valid/ready stream and keeps the two trailing check bytes for a CRC unit that sits outside the block. On a write, the engine sends the start token, the host's bytes and two filler check bytes. It then reads the card's data response and polls until the card stops signalling busy. A multi-block write repeats this for each block and closes the sequence with a stop token. Every operation ends with a one-cycle `done` pulse and a two-bit status.

The engine also works out the command argument for a block number. High-capacity cards take the block number itself, and other cards take the byte address.

Top module: `sd_blk_engine`

## Requirements
- R1: After a read start, the engine exchanges filler 0xFF bytes and discards what it receives until the card returns 0xFE. The first data exchange follows the token.
- R2: If none of the first TOKEN_POLLS received bytes is 0xFE, the read ends with status 3 (timeout) after exactly TOKEN_POLLS exchanges, and no data byte is offered to the host.
- R3: A read delivers BLOCK_BYTES bytes in card order on `rd_valid`/`rd_ready`, transmitting 0xFF for each one. While `rd_ready` is low, `rd_data` holds and no new exchange starts.
- R4: The two bytes after the read data are captured into `rd_crc`, the first one in bits 15:8. The read then ends with status 0 (accepted).
- R5: A write sends a start token, BLOCK_BYTES bytes taken in order from the `wr_valid`/`wr_ready` stream, and then two 0xFF check bytes. The token is 0xFE for a single-block write (`op` = 01) and 0xFC for every block of a multi-block write (`op` = 1x).
- R6: After the check bytes the engine sends 0xFF, reads one response byte and decodes its low five bits. 0x05 gives status 0, 0x0B gives status 1 (CRC error), and 0x0D or any other value gives status 2 (write error). Bits 7:5 are ignored.
- R7: After the response, the engine sends 0xFF until it receives 0xFF. If none of BUSY_POLLS polls returns 0xFF, it ends at once with status 3 and sends nothing further.
- R8: A multi-block write of `blk_count` blocks (0 counts as 1) ends after the last block's busy period. The engine sends 0xFD, polls busy again, and then reports status 0.
- R9: If a block in a multi-block write gets a non-accepted response, the engine sends no further blocks. After that block's busy period it sends 0xFD and reports the failing block's status.
- R10: `card_arg` equals `blk_num` when `high_cap` is 1, and `blk_num` × BLOCK_BYTES (truncated to 32 bits) otherwise.
- R11: `start` is ignored while `busy` is high. `done` lasts one cycle. A `start` present in the cycle of `done` launches the next operation, so `busy` is high in the following cycle.
- R12: After reset, `busy`, `done`, `xfer_req`, `rd_valid` and `wr_ready` are low and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 00 read, 01 single-block write, 1x multi-block write |
| blk_count | input | CNT_W | Blocks in a multi-block write (0 taken as 1) |
| blk_num | input | 32 | Block number to convert |
| high_cap | input | 1 | Card uses block addressing |
| card_arg | output | 32 | Command argument for `blk_num` |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send in the exchange |
| xfer_done | input | 1 | Exchange complete, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received in the exchange |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Host takes the read byte |
| rd_crc | output | 16 | Check bytes captured from the last read |
| wr_valid | input | 1 | Host offers a write byte |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Engine takes the write byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 0 accepted, 1 CRC error, 2 write error, 3 timeout |

## Verification
The end of one operation and the request for the next one can fall in the same cycle. The bench holds `start` high through a whole read. It checks that the held request does not restart the running read: the exchange count must match a single read. It then checks that `busy` is high in the cycle after `done`, and that the follow-on read runs its full token hunt and times out. In a second pairing, the host stream stalls on a fixed cycle pattern during reads and writes, so `rd_ready` drops as a byte is offered and `wr_valid` drops as a byte is wanted. The bench checks every delivered byte against its own pattern.

// File: rtl/sd_blk_pkg.sv
`timescale 1ns/1ps
package sd_blk_pkg;

  typedef enum logic [1:0] {
    BLK_OK      = 2'd0,
    BLK_CRC_ERR = 2'd1,
    BLK_WR_ERR  = 2'd2,
    BLK_TIMEOUT = 2'd3
  } blk_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HUNT, S_RDATA, S_RPUSH, S_RCRC,
    S_WTOK, S_WPULL, S_WDATA, S_WCRC, S_WRESP,
    S_WBUSY, S_WSTOP, S_SBUSY
  } eng_state_e;

  localparam logic [7:0] TK_SINGLE = 8'hFE;
  localparam logic [7:0] TK_MULTI  = 8'hFC;
  localparam logic [7:0] TK_STOP   = 8'hFD;
  localparam logic [7:0] TK_FILL   = 8'hFF;

  // Low five bits of the card's data response select the outcome.
  function automatic blk_status_e decode_resp(input logic [7:0] b);
    logic [7:0] m;
    m = b & 8'h1F;
    case (m)
      8'h05:   return BLK_OK;
      8'h0B:   return BLK_CRC_ERR;
      8'h0D:   return BLK_WR_ERR;
      default: return BLK_WR_ERR;
    endcase
  endfunction

  function automatic logic [31:0] scale_addr(input logic [31:0] blk, input logic hc,
                                             input int unsigned shift);
    return hc ? blk : (blk << shift);
  endfunction

endpackage

// File: rtl/sd_blk_cnt.sv
`timescale 1ns/1ps
module sd_blk_cnt #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  generate
    if (LIMIT <= 1) begin : g_single
      assign last = 1'b1;
    end else begin : g_count
      localparam int W = $clog2(LIMIT);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
      end
      assign last = (cnt == W'(LIMIT - 1));
    end
  endgenerate
endmodule

// File: rtl/sd_blk_resp_dec.sv
`timescale 1ns/1ps
module sd_blk_resp_dec
  import sd_blk_pkg::*;
(
  input  logic [7:0]  resp_byte,
  output blk_status_e code,
  output logic        accepted
);
  assign code     = decode_resp(resp_byte);
  assign accepted = (code == BLK_OK);
endmodule

// File: rtl/sd_blk_addr_map.sv
`timescale 1ns/1ps
module sd_blk_addr_map
  import sd_blk_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic [31:0] blk,
  input  logic        high_cap,
  output logic [31:0] arg
);
  localparam bit POW2 = ((BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0);
  generate
    if (POW2) begin : g_shift
      assign arg = scale_addr(blk, high_cap, $clog2(BLOCK_BYTES));
    end else begin : g_mul
      assign arg = high_cap ? blk : (blk * 32'(BLOCK_BYTES));
    end
  endgenerate
endmodule

// File: rtl/sd_blk_engine.sv
`timescale 1ns/1ps
module sd_blk_engine
  import sd_blk_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int TOKEN_POLLS = 1024,
  parameter int BUSY_POLLS  = 65536,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [31:0]      blk_num,
  input  logic             high_cap,
  output logic [31:0]      card_arg,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic [15:0]      rd_crc,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status
);

  eng_state_e       st;
  blk_status_e      blk_st, status_q, rsp_code;
  logic             multi_q, crc_second, rsp_ok;
  logic [CNT_W-1:0] blk_rem;
  logic [7:0]       hold;

  // Named events, also used by the bound checker.
  logic in_hunt, in_busy, byte_last, tok_last, bsy_last, blk_last;
  logic ev_tok_seen, ev_poll_expire, ev_resp_taken;
  logic byte_clr, byte_step;

  assign in_hunt  = (st == S_HUNT);
  assign in_busy  = (st == S_WBUSY) || (st == S_SBUSY);
  assign blk_last = (blk_rem == CNT_W'(1));

  assign ev_tok_seen    = in_hunt && xfer_done && (xfer_rx == TK_SINGLE);
  assign ev_poll_expire = (in_hunt && xfer_done && (xfer_rx != TK_SINGLE) && tok_last) ||
                          (in_busy && xfer_done && (xfer_rx != TK_FILL) && bsy_last);
  assign ev_resp_taken  = (st == S_WRESP) && xfer_done;

  assign byte_clr  = (st == S_IDLE) || (st == S_WTOK) || in_hunt;
  assign byte_step = ((st == S_RPUSH) && rd_ready) || ((st == S_WDATA) && xfer_done);

  sd_blk_cnt #(.LIMIT(BLOCK_BYTES)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(byte_clr), .step(byte_step), .last(byte_last)
  );

  sd_blk_cnt #(.LIMIT(TOKEN_POLLS)) u_tok_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!in_hunt), .step(in_hunt && xfer_done), .last(tok_last)
  );

  sd_blk_cnt #(.LIMIT(BUSY_POLLS)) u_bsy_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!in_busy), .step(in_busy && xfer_done), .last(bsy_last)
  );

  sd_blk_resp_dec u_dec (
    .resp_byte(xfer_rx), .code(rsp_code), .accepted(rsp_ok)
  );

  sd_blk_addr_map #(.BLOCK_BYTES(BLOCK_BYTES)) u_addr (
    .blk(blk_num), .high_cap(high_cap), .arg(card_arg)
  );

  // Exchange requests and transmitted byte per state.
  always_comb begin
    xfer_req = 1'b0;
    xfer_tx  = TK_FILL;
    case (st)
      S_HUNT, S_RDATA, S_RCRC, S_WCRC, S_WRESP, S_WBUSY, S_SBUSY: xfer_req = 1'b1;
      S_WTOK: begin
        xfer_req = 1'b1;
        xfer_tx  = multi_q ? TK_MULTI : TK_SINGLE;
      end
      S_WDATA: begin
        xfer_req = 1'b1;
        xfer_tx  = hold;
      end
      S_WSTOP: begin
        xfer_req = 1'b1;
        xfer_tx  = TK_STOP;
      end
      default: ;
    endcase
  end

  assign rd_valid = (st == S_RPUSH);
  assign rd_data  = hold;
  assign wr_ready = (st == S_WPULL);
  assign busy     = (st != S_IDLE);
  assign status   = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      multi_q    <= 1'b0;
      blk_rem    <= '0;
      hold       <= '0;
      crc_second <= 1'b0;
      blk_st     <= BLK_OK;
      status_q   <= BLK_OK;
      done       <= 1'b0;
      rd_crc     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          crc_second <= 1'b0;
          multi_q    <= op[1];
          blk_rem    <= (blk_count == '0) ? CNT_W'(1) : blk_count;
          blk_st     <= BLK_OK;
          if (op == 2'b00) begin
            rd_crc <= '0;
            st     <= S_HUNT;
          end else begin
            st <= S_WTOK;
          end
        end
        S_HUNT: if (xfer_done) begin
          if (xfer_rx == TK_SINGLE) st <= S_RDATA;
          else if (tok_last) begin
            done     <= 1'b1;
            status_q <= BLK_TIMEOUT;
            st       <= S_IDLE;
          end
        end
        S_RDATA: if (xfer_done) begin
          hold <= xfer_rx;
          st   <= S_RPUSH;
        end
        S_RPUSH: if (rd_ready) st <= byte_last ? S_RCRC : S_RDATA;
        S_RCRC: if (xfer_done) begin
          rd_crc     <= {rd_crc[7:0], xfer_rx};
          crc_second <= !crc_second;
          if (crc_second) begin
            done     <= 1'b1;
            status_q <= BLK_OK;
            st       <= S_IDLE;
          end
        end
        S_WTOK:  if (xfer_done) st <= S_WPULL;
        S_WPULL: if (wr_valid) begin
          hold <= wr_data;
          st   <= S_WDATA;
        end
        S_WDATA: if (xfer_done) st <= byte_last ? S_WCRC : S_WPULL;
        S_WCRC: if (xfer_done) begin
          crc_second <= !crc_second;
          if (crc_second) st <= S_WRESP;
        end
        S_WRESP: if (xfer_done) begin
          blk_st <= rsp_ok ? BLK_OK : rsp_code;
          st     <= S_WBUSY;
        end
        S_WBUSY: if (xfer_done) begin
          if (xfer_rx == TK_FILL) begin
            if (multi_q) begin
              if ((blk_st != BLK_OK) || blk_last) st <= S_WSTOP;
              else begin
                blk_rem <= blk_rem - 1'b1;
                st      <= S_WTOK;
              end
            end else begin
              done     <= 1'b1;
              status_q <= blk_st;
              st       <= S_IDLE;
            end
          end else if (bsy_last) begin
            done     <= 1'b1;
            status_q <= BLK_TIMEOUT;
            st       <= S_IDLE;
          end
        end
        S_WSTOP: if (xfer_done) st <= S_SBUSY;
        S_SBUSY: if (xfer_done) begin
          if (xfer_rx == TK_FILL) begin
            done     <= 1'b1;
            status_q <= blk_st;
            st       <= S_IDLE;
          end else if (bsy_last) begin
            done     <= 1'b1;
            status_q <= BLK_TIMEOUT;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_blk_engine_chk.sv
`timescale 1ns/1ps
module sd_blk_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_done,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_ready,
  input logic       wr_ready,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       ev_tok_seen,
  input logic       ev_poll_expire,
  input logic       ev_resp_taken
);

  // R3: a stalled read byte stays offered and unchanged
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R3: host stream handshakes never overlap a card exchange
  a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_ready, xfer_req}));

  // R5: an exchange in flight keeps its byte until completion
  a_r5_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_tx));

  // R1: the token is followed by a filler exchange for the first data byte
  a_r1_token_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tok_seen |=> xfer_req && xfer_tx == 8'hFF);

  // R2 / R7: an expired poll window ends the operation with timeout
  a_r2_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll_expire |=> done && status == 2'd3 && !busy);

  // R7: the response byte is followed by busy polling with filler
  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_taken |=> xfer_req && xfer_tx == 8'hFF);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: done is raised only as the engine returns to idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !xfer_req);

endmodule

bind sd_blk_engine sd_blk_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
  .xfer_done(xfer_done), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_ready(rd_ready), .wr_ready(wr_ready), .busy(busy), .done(done),
  .status(status), .ev_tok_seen(ev_tok_seen), .ev_poll_expire(ev_poll_expire),
  .ev_resp_taken(ev_resp_taken)
);

// File: tb/sim_sd_blk_engine.sv
`timescale 1ns/1ps
module sim_sd_blk_engine;
  localparam int BB = 512;
  localparam int TP = 8;
  localparam int BP = 16;
  localparam int CW = 4;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start, high_cap, xfer_req, xfer_done, rd_valid, rd_ready;
  logic          wr_valid, wr_ready, busy, done;
  logic [1:0]    op, status;
  logic [CW-1:0] blk_count;
  logic [31:0]   blk_num, card_arg;
  logic [7:0]    xfer_tx, xfer_rx, rd_data, wr_data;
  logic [15:0]   rd_crc;

  sd_blk_engine #(.BLOCK_BYTES(BB), .TOKEN_POLLS(TP), .BUSY_POLLS(BP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk_count(blk_count),
    .blk_num(blk_num), .high_cap(high_cap), .card_arg(card_arg),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .rd_crc(rd_crc),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .status(status)
  );

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 13 + s * 29 + 5) & 255);
  endfunction

  // Card model: one exchange answered per request, one cycle later.
  logic [7:0] script [DEPTH];
  logic [7:0] exp_tx [DEPTH];
  logic [7:0] txlog  [DEPTH];
  int sp, tp, rp, wp, rd_bad, cyc, n, seed;
  logic mclr, stall_en;

  always @(posedge clk) begin
    if (!rst_n || mclr) begin
      xfer_done <= 1'b0;
      xfer_rx   <= 8'hFF;
      sp <= 0;
      tp <= 0;
    end else if (xfer_req && !xfer_done) begin
      xfer_done <= 1'b1;
      xfer_rx   <= (sp < DEPTH) ? script[sp] : 8'hFF;
      if (tp < DEPTH) txlog[tp] <= xfer_tx;
      sp <= sp + 1;
      tp <= tp + 1;
    end else begin
      xfer_done <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || mclr) begin
      rp <= 0; wp <= 0; rd_bad <= 0;
    end else begin
      if (rd_valid && rd_ready) begin
        if (rd_data !== pat(rp, seed)) rd_bad <= rd_bad + 1;
        rp <= rp + 1;
      end
      if (wr_valid && wr_ready) wp <= wp + 1;
    end
  end

  assign rd_ready = !stall_en || (cyc % 3 != 0);
  assign wr_valid = !stall_en || (cyc % 4 != 1);
  assign wr_data  = pat(wp, seed);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] card_b, input logic [7:0] host_b);
    script[n] = card_b;
    exp_tx[n] = host_b;
    n++;
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) script[i] = 8'hFF;
    n = 0;
  endtask

  task automatic build_read(input int pre, input logic [15:0] crc);
    int k;
    k = (pre < TP) ? pre : TP;
    for (int i = 0; i < k; i++) put(8'hFF, 8'hFF);
    if (pre < TP) begin
      put(8'hFE, 8'hFF);
      for (int i = 0; i < BB; i++) put(pat(i, seed), 8'hFF);
      put(crc[15:8], 8'hFF);
      put(crc[7:0], 8'hFF);
    end
  endtask

  task automatic build_write(input bit multi, input int nblk, input int fail_at,
                             input logic [7:0] resp, input int busyz);
    bit tmo;
    int z;
    tmo = 1'b0;
    for (int b = 0; b < nblk; b++) begin
      put(8'hFF, multi ? 8'hFC : 8'hFE);
      for (int i = 0; i < BB; i++) put(8'hFF, pat(b * BB + i, seed));
      put(8'hFF, 8'hFF);
      put(8'hFF, 8'hFF);
      put((b == fail_at) ? resp : 8'hE5, 8'hFF);
      z = (busyz < BP) ? busyz : BP;
      for (int i = 0; i < z; i++) put(8'h00, 8'hFF);
      if (busyz < BP) put(8'hFF, 8'hFF);
      else tmo = 1'b1;
      if (tmo || b == fail_at) break;
    end
    if (multi && !tmo) begin
      put(8'hFF, 8'hFD);
      put(8'h00, 8'hFF);
      put(8'hFF, 8'hFF);
    end
  endtask

  task automatic pulse_mclr();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] st_o, output bit got);
    got = 1'b0;
    st_o = 2'd0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        st_o = status;
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic launch(input logic [1:0] o, input int cnt);
    @(negedge clk);
    op = o;
    blk_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic cmp_tx(input string req);
    int bad;
    bad = 0;
    check(tp == n, req, "exchange count", 32'(tp), 32'(n));
    for (int i = 0; i < n && i < tp; i++) if (txlog[i] !== exp_tx[i]) bad++;
    check(bad == 0, req, "transmitted bytes mismatching", 32'(bad), 32'd0);
  endtask

  // Vector table: op, blocks, lead (pre-token filler or busy zeros), response,
  // failing block index (15 = none), expected status.
  typedef struct packed {
    logic [1:0] op;
    logic [3:0] nblk;
    logic [7:0] lead;
    logic [7:0] resp;
    logic [3:0] fail_at;
    logic [1:0] exp_st;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd1, 8'd0,  8'h00, 4'hF, 2'd0},
    '{2'd0, 4'd1, 8'd7,  8'h00, 4'hF, 2'd0},
    '{2'd0, 4'd1, 8'd8,  8'h00, 4'hF, 2'd3},
    '{2'd1, 4'd1, 8'd3,  8'hE5, 4'd0, 2'd0},
    '{2'd1, 4'd1, 8'd1,  8'hEB, 4'd0, 2'd1},
    '{2'd1, 4'd1, 8'd15, 8'h0D, 4'd0, 2'd2},
    '{2'd1, 4'd1, 8'd16, 8'hE5, 4'd0, 2'd3},
    '{2'd1, 4'd1, 8'd0,  8'h07, 4'd0, 2'd2},
    '{2'd2, 4'd3, 8'd2,  8'h00, 4'hF, 2'd0},
    '{2'd2, 4'd3, 8'd2,  8'h0D, 4'd1, 2'd2}
  };
  localparam string VTAG [NV] = '{
    "R1 R4", "R1 R4", "R2", "R5 R6 R7", "R6", "R6 R7",
    "R7", "R6", "R8", "R9"
  };

  initial begin
    #(190000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    bit got;
    rst_n = 1'b0; start = 1'b0; op = 2'd0; blk_count = '0;
    blk_num = '0; high_cap = 1'b0; mclr = 1'b0; stall_en = 1'b0;
    seed = 0; cyc = 0;
    clear_model();
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!busy && !done, "R12", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    check(!xfer_req && !rd_valid && !wr_ready, "R12", "request lines after reset",
          {29'd0, xfer_req, rd_valid, wr_ready}, 32'd0);
    check(status == 2'd0, "R12", "status after reset", 32'(status), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: address conversion
    blk_num = 32'h0000_0123; high_cap = 1'b0;
    @(negedge clk);
    check(card_arg == 32'h0002_4600, "R10", "byte address", card_arg, 32'h0002_4600);
    high_cap = 1'b1;
    @(negedge clk);
    check(card_arg == 32'h0000_0123, "R10", "block address", card_arg, 32'h0000_0123);

    for (int v = 0; v < NV; v++) begin
      seed = v + 1;
      clear_model();
      if (VEC[v].op == 2'd0) build_read(int'(VEC[v].lead), 16'hA5C3 ^ 16'(v));
      else build_write(VEC[v].op[1], int'(VEC[v].nblk), int'(VEC[v].fail_at),
                       VEC[v].resp, int'(VEC[v].lead));
      pulse_mclr();
      launch(VEC[v].op, int'(VEC[v].nblk));
      wait_done(st, got);
      check(got, VTAG[v], "done seen", 32'(got), 32'd1);
      check(st == VEC[v].exp_st, VTAG[v], "status", 32'(st), 32'(VEC[v].exp_st));
      cmp_tx(VTAG[v]);
      if (VEC[v].op == 2'd0) begin
        if (VEC[v].exp_st == 2'd0) begin
          check(rp == BB && rd_bad == 0, "R3", "read bytes delivered/bad",
                32'(rp) | (32'(rd_bad) << 16), 32'(BB));
          check(rd_crc == (16'hA5C3 ^ 16'(v)), "R4", "captured check bytes",
                32'(rd_crc), 32'(16'hA5C3 ^ 16'(v)));
        end else begin
          check(rp == 0, "R2", "bytes offered on timeout", 32'(rp), 32'd0);
        end
      end
    end

    // R3: read with host stalls
    seed = 40; stall_en = 1'b1;
    clear_model();
    build_read(3, 16'h1234);
    pulse_mclr();
    launch(2'd0, 1);
    wait_done(st, got);
    check(got && st == 2'd0, "R3", "stalled read status", 32'(st), 32'd0);
    check(rp == BB && rd_bad == 0, "R3", "stalled read bytes/bad",
          32'(rp) | (32'(rd_bad) << 16), 32'(BB));
    cmp_tx("R3");

    // R5 R8: multi-block write with a stalling source, two blocks
    seed = 41;
    clear_model();
    build_write(1'b1, 2, 15, 8'h00, 1);
    pulse_mclr();
    launch(2'd3, 2);
    wait_done(st, got);
    check(got && st == 2'd0, "R8", "stalled multi write status", 32'(st), 32'd0);
    cmp_tx("R5");
    stall_en = 1'b0;

    // R11: start held through a read, then coinciding with done
    seed = 42;
    clear_model();
    build_read(0, 16'h0F0F);
    for (int i = 0; i < TP; i++) put(8'hFF, 8'hFF);
    pulse_mclr();
    @(negedge clk);
    op = 2'd0; start = 1'b1;
    wait_done(st, got);
    check(got && st == 2'd0, "R11", "first read status", 32'(st), 32'd0);
    check(tp == BB + 3, "R11", "exchanges of first read", 32'(tp), 32'(BB + 3));
    @(negedge clk);
    check(busy == 1'b1, "R11", "busy after start coinciding with done", 32'(busy), 32'd1);
    start = 1'b0;
    wait_done(st, got);
    check(got && st == 2'd3, "R11", "follow-on read times out", 32'(st), 32'd3);
    cmp_tx("R11");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule